// File: doc/BRIEF.md
# Paired Address/Operand Register File

This block holds eight address registers, each tied to the operand register with the same index. Any write to an address register also starts a memory transfer for its partner. Indices below a load threshold (0 to 5 by default) read memory at the new address into the partner operand register. Indices 6 and 7 write the partner operand register to memory at the new address. An address register can be set to a literal or advanced by an immediate. Advancing by one moves through an array and fetches or writes one element per step.

Operand registers also take three-register arithmetic: a destination and two sources, combined by add, subtract, AND or OR. Only one memory transfer can be in flight at a time. While it waits, `busy` is high and every command is dropped. An arithmetic command that follows a load is therefore accepted only after the loaded value is in place. A read-out port shows any address/operand pair.

Top module: `paired_regfile`

## Requirements
- R1: After reset, `busy` and `mem_req` are 0 and every address and operand register reads 0.
- R2: Command `cmd_op`=0 (set) with `cmd_dst` in 0..5 writes `cmd_imm` into that address register. It then issues one memory read (`mem_we`=0) at that address, and the returned `mem_rdata` lands in the paired operand register.
- R3: A set or step command with `cmd_dst` of 6 or 7 issues one memory write (`mem_we`=1) at the new address. The write data is the paired operand register as it was when the command was accepted. The operand register itself is unchanged.
- R4: Command `cmd_op`=1 (step) writes address register `cmd_dst` with its old value plus `cmd_imm`, wrapping modulo 2^16. It triggers the same transfer as R2 or R3, depending on the index.
- R5: Command `cmd_op`=2 writes operand register `cmd_dst` one cycle after acceptance. The value is src_a op src_b, selected by `cmd_fn`: 0 add, 1 subtract (a minus b), 2 AND, 3 OR. No memory request is made.
- R6: `busy` goes high in the cycle after an address command is accepted. It stays high until the edge where `mem_ready` is seen with `mem_req`. Every command presented while `busy` is high is ignored.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R8: An arithmetic command issued right after a load reads the loaded value, including when it names the loaded register as both source and destination.
- R9: Command `cmd_op`=3, or any command with `cmd_valid` low, changes no register and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 set address, 1 step address, 2 arithmetic, 3 no-op |
| cmd_fn | input | 2 | Arithmetic function |
| cmd_dst | input | 3 | Destination register index |
| cmd_src_a | input | 3 | First source operand index |
| cmd_src_b | input | 3 | Second source operand index |
| cmd_imm | input | 16 | Literal address or step amount |
| busy | output | 1 | Memory transfer pending; commands dropped |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| rd_sel | input | 3 | Read-out index |
| rd_addr | output | 16 | Selected address register |
| rd_opnd | output | 16 | Selected operand register |

## Verification
The bench steps an address register from 0xFFFF by one. A design that drops the carry wrap, or fetches from the old address, reports the wrong load address. The bench holds an arithmetic command through the whole busy window. A design that does not drop it during the stall corrupts the destination operand register. An arithmetic command that uses a just-loaded register as source and destination exposes a design that reads the operand before the memory data is written. Stores at indices 6 and 7 are checked for data captured at issue and for an operand register left untouched. The memory model inserts random wait states, so a request that drifts before `mem_ready` makes the model log a wrong address.

// File: rtl/prf_pkg.sv
package prf_pkg;

    typedef enum logic [1:0] {
        CMD_SETA = 2'd0,
        CMD_STEP = 2'd1,
        CMD_ALU  = 2'd2,
        CMD_NOP  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_OR  = 2'd3
    } fn_e;

endpackage

// File: rtl/prf_alu.sv
module prf_alu
    import prf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        fn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    always_comb begin
        unique case (fn_e'(fn_i))
            FN_ADD:  y_o = a_i + b_i;
            FN_SUB:  y_o = a_i - b_i;
            FN_AND:  y_o = a_i & b_i;
            default: y_o = a_i | b_i;
        endcase
    end

endmodule

// File: rtl/prf_xfer.sv
module prf_xfer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_we_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [DATA_W-1:0] start_data_i,
    input  logic [IDX_W-1:0]  start_idx_i,
    input  logic              mem_ready_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              done_o,
    output logic              done_we_o,
    output logic [IDX_W-1:0]  done_idx_o,
    output logic              busy_o
);

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  idx;
    } xfer_t;

    xfer_t x_d, x_q;

    always_comb begin
        x_d = x_q;
        if (x_q.req && mem_ready_i) begin
            x_d.req = 1'b0;
        end
        if (start_i) begin
            x_d.req  = 1'b1;
            x_d.we   = start_we_i;
            x_d.addr = start_addr_i;
            x_d.data = start_data_i;
            x_d.idx  = start_idx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    assign mem_req_o   = x_q.req;
    assign mem_we_o    = x_q.we;
    assign mem_addr_o  = x_q.addr;
    assign mem_wdata_o = x_q.data;
    assign done_o      = x_q.req && mem_ready_i;
    assign done_we_o   = x_q.we;
    assign done_idx_o  = x_q.idx;
    assign busy_o      = x_q.req;

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !mem_req_o);

endmodule

// File: rtl/paired_regfile.sv
module paired_regfile
    import prf_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 16,
    parameter int NREG       = 8,
    parameter int LOAD_COUNT = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [1:0]              cmd_fn,
    input  logic [$clog2(NREG)-1:0] cmd_dst,
    input  logic [$clog2(NREG)-1:0] cmd_src_a,
    input  logic [$clog2(NREG)-1:0] cmd_src_b,
    input  logic [ADDR_W-1:0]       cmd_imm,
    output logic                    busy,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ready,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic [$clog2(NREG)-1:0] rd_sel,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_opnd
);

    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][ADDR_W-1:0] areg;
        logic [NREG-1:0][DATA_W-1:0] oreg;
    } rf_t;

    rf_t rf_d, rf_q;

    logic              accept;
    logic              x_start;
    logic              x_start_we;
    logic [ADDR_W-1:0] x_start_addr;
    logic [DATA_W-1:0] x_start_data;
    logic              x_done;
    logic              x_done_we;
    logic [IDX_W-1:0]  x_done_idx;
    logic              x_busy;
    logic [DATA_W-1:0] alu_y;

    prf_alu #(.DATA_W(DATA_W)) u_alu (
        .fn_i (cmd_fn),
        .a_i  (rf_q.oreg[cmd_src_a]),
        .b_i  (rf_q.oreg[cmd_src_b]),
        .y_o  (alu_y)
    );

    prf_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (x_start),
        .start_we_i   (x_start_we),
        .start_addr_i (x_start_addr),
        .start_data_i (x_start_data),
        .start_idx_i  (cmd_dst),
        .mem_ready_i  (mem_ready),
        .mem_req_o    (mem_req),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata),
        .done_o       (x_done),
        .done_we_o    (x_done_we),
        .done_idx_o   (x_done_idx),
        .busy_o       (x_busy)
    );

    assign accept = cmd_valid && !x_busy;

    always_comb begin
        rf_d         = rf_q;
        x_start      = 1'b0;
        x_start_we   = (32'(cmd_dst) >= LOAD_COUNT);
        x_start_addr = (cmd_e'(cmd_op) == CMD_SETA) ? cmd_imm
                                                    : rf_q.areg[cmd_dst] + cmd_imm;
        x_start_data = rf_q.oreg[cmd_dst];

        if (x_done && !x_done_we) begin
            rf_d.oreg[x_done_idx] = mem_rdata;
        end

        if (accept) begin
            unique case (cmd_e'(cmd_op))
                CMD_SETA, CMD_STEP: begin
                    rf_d.areg[cmd_dst] = x_start_addr;
                    x_start            = 1'b1;
                end
                CMD_ALU: begin
                    rf_d.oreg[cmd_dst] = alu_y;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign busy    = x_busy;
    assign rd_addr = rf_q.areg[rd_sel];
    assign rd_opnd = rf_q.oreg[rd_sel];

    assert_busy_after_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_op == 2'd0 || cmd_op == 2'd1)) |=> busy);

    assert_ignore_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> $stable(rf_q));

    assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=> (rf_q.oreg[$past(x_done_idx)] == $past(mem_rdata)));

    assert_alu_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == 2'd2) |=> !mem_req);

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (!cmd_valid || cmd_op == 2'd3)) |=> ($stable(rf_q) && !mem_req));

endmodule

// File: tb/paired_regfile_test.sv
module paired_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int N  = 8;
    localparam int NLOAD = 6;

    logic          clk, rst_n;
    logic          cmd_valid;
    logic [1:0]    cmd_op, cmd_fn;
    logic [2:0]    cmd_dst, cmd_src_a, cmd_src_b;
    logic [AW-1:0] cmd_imm;
    logic          busy, mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [2:0]    rd_sel;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_opnd;

    paired_regfile uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_fn(cmd_fn), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a),
        .cmd_src_b(cmd_src_b), .cmd_imm(cmd_imm), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_opnd(rd_opnd)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int cycles = 0;

    logic [AW-1:0] exp_a [N];
    logic [DW-1:0] exp_o [N];

    int            ld_count = 0, st_count = 0, wait_cnt = 2;
    logic [AW-1:0] last_ld_addr, last_st_addr;
    logic [DW-1:0] last_st_data;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return a * 16'd37 + 16'h1234;
    endfunction

    function automatic logic [DW-1:0] alu(input logic [1:0] fn, input logic [DW-1:0] a, b);
        case (fn)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a & b;
            default: return a | b;
        endcase
    endfunction

    // memory model with random wait states
    always @(negedge clk) begin
        if (mem_req && !mem_ready) begin
            if (wait_cnt == 0) begin
                mem_ready = 1'b1;
                mem_rdata = memf(mem_addr);
                if (mem_we) begin
                    st_count++;
                    last_st_addr = mem_addr;
                    last_st_data = mem_wdata;
                end else begin
                    ld_count++;
                    last_ld_addr = mem_addr;
                end
                wait_cnt = $urandom % 4;
            end else begin
                wait_cnt--;
            end
        end else begin
            mem_ready = 1'b0;
            mem_rdata = 16'hDEAD;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) begin
            rd_sel = 3'(i);
            #1;
            chk(tag, 32'(rd_addr), 32'(exp_a[i]));
            chk(tag, 32'(rd_opnd), 32'(exp_o[i]));
        end
    endtask

    task automatic do_addr(input logic [1:0] op, input int dst, input logic [AW-1:0] imm,
                           input string tag);
        int ld0, st0;
        logic [AW-1:0] na;
        @(negedge clk);
        ld0 = ld_count; st0 = st_count;
        cmd_valid = 1'b1; cmd_op = op; cmd_dst = 3'(dst); cmd_imm = imm;
        cmd_src_a = 3'($urandom); cmd_src_b = 3'($urandom); cmd_fn = 2'($urandom);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " R6 busy"}, 32'(busy), 32'd1);
        while (busy) @(negedge clk);
        na = (op == 2'd0) ? imm : exp_a[dst] + imm;
        exp_a[dst] = na;
        if (dst < NLOAD) begin
            chk({tag, " R2 load count"}, ld_count, ld0 + 1);
            chk({tag, " R2 load addr"}, 32'(last_ld_addr), 32'(na));
            exp_o[dst] = memf(na);
        end else begin
            chk({tag, " R3 store count"}, st_count, st0 + 1);
            chk({tag, " R3 store addr"}, 32'(last_st_addr), 32'(na));
            chk({tag, " R3 store data"}, 32'(last_st_data), 32'(exp_o[dst]));
        end
    endtask

    task automatic do_alu(input logic [1:0] fn, input int d, input int a, input int b,
                          input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_fn = fn;
        cmd_dst = 3'(d); cmd_src_a = 3'(a); cmd_src_b = 3'(b); cmd_imm = 16'($urandom);
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_o[d] = alu(fn, exp_o[a], exp_o[b]);
        chk({tag, " R5 no mem"}, 32'(mem_req), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd3; cmd_fn = 2'd0;
        cmd_dst = '0; cmd_src_a = '0; cmd_src_b = '0; cmd_imm = '0; rd_sel = '0;
        mem_ready = 1'b0; mem_rdata = '0;
        for (int i = 0; i < N; i++) begin exp_a[i] = '0; exp_o[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        check_all("R1 regs");

        // loads into every low register
        for (int i = 0; i < NLOAD; i++) do_addr(2'd0, i, 16'(16'h0100 + i * 7), "R2 set");
        check_all("R2 after loads");

        // stores keep the operand register
        do_alu(2'd0, 6, 0, 1, "R5 add");
        do_addr(2'd0, 6, 16'h4000, "R3 set");
        check_all("R3 operand kept");
        do_addr(2'd1, 7, 16'd1, "R4 store step");
        check_all("R4 store step");

        // step with wrap
        do_addr(2'd0, 2, 16'hFFFF, "R2 set top");
        do_addr(2'd1, 2, 16'd1, "R4 wrap");
        do_addr(2'd1, 2, 16'd1, "R4 step");
        check_all("R4 array walk");

        // each arithmetic function
        do_alu(2'd1, 3, 0, 1, "R5 sub");
        do_alu(2'd2, 4, 1, 2, "R5 and");
        do_alu(2'd3, 5, 0, 2, "R5 or");
        check_all("R5 functions");

        // arithmetic right after a load, same register as source and destination
        do_addr(2'd0, 1, 16'h2222, "R8 load");
        do_alu(2'd0, 1, 1, 1, "R8 self add");
        check_all("R8 after load");

        // command held during the busy window is dropped
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_dst = 3'd0; cmd_imm = 16'h0777;
        @(negedge clk);
        chk("R6 busy in window", 32'(busy), 32'd1);
        cmd_op = 2'd2; cmd_fn = 2'd3; cmd_dst = 3'd3; cmd_src_a = 3'd0; cmd_src_b = 3'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        exp_a[0] = 16'h0777; exp_o[0] = memf(16'h0777);
        check_all("R6 dropped while busy");

        // no-op and idle commands
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_dst = 3'd2; cmd_imm = 16'h1111;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        chk("R9 no-op no mem", 32'(mem_req), 32'd0);
        repeat (2) @(negedge clk);
        chk("R9 idle no mem", 32'(mem_req), 32'd0);
        check_all("R9 regs unchanged");

        // random mix
        for (int k = 0; k < 120; k++) begin
            int sel;
            sel = $urandom % 3;
            if (sel == 2)
                do_alu(2'($urandom), int'($urandom % N), int'($urandom % N), int'($urandom % N), "R5 random");
            else if (sel == 1)
                do_addr(2'd1, int'($urandom % N), 16'($urandom % 3), "R4 random");
            else
                do_addr(2'd0, int'($urandom % N), 16'($urandom), "R2/R3 random");
        end
        check_all("R2/R3/R4/R5 random final");

        finish_run();
    end

endmodule